// File: doc/BRIEF.md
# Bit-Serial Four-Tap FIR Filter

This block computes a four-tap finite impulse response filter, y(n) = K0·x(n) + K1·x(n-1) + K2·x(n-2) + K3·x(n-3), using one bit of datapath per cycle in place of four multipliers and an adder tree. Input samples arrive one bit per cycle, least significant bit first, over a valid/ready stream. When a sample's eighth bit is accepted, the sample is pushed into a four-entry history and a computation starts.

The taps are handled one after another, from the oldest sample to the newest. For each tap, a serial-parallel multiplier receives the sample one bit at a time and the coefficient as a whole word. It produces the product one bit per cycle. A single full adder with a carry flop adds that product stream into a rotating accumulator. The coefficients are written through a plain write port.

Back-pressure rules: the input side accepts a bit on any cycle where both `s_valid` and `s_ready` are high. `s_ready` stays low while a result is being computed, so a sender simply holds its bit until `s_ready` returns. The result side has no back-pressure. `y_valid` pulses for one cycle, and `y` holds its value until the next result is ready.

Top module: `fir_bitserial`

## Requirements
- R1: After reset, `s_ready` is 1, `y_valid` is 0 and `y` is 0. All four coefficients and all four history entries are 0.
- R2: An input bit is taken on a rising edge where `s_valid` and `s_ready` are both 1. Eight bits taken in a row form one unsigned sample, with the first bit as bit 0 and the last as bit 7.
- R3: `s_ready` is 0 from the edge that takes a sample's eighth bit until the result for that sample is presented. Bits offered while `s_ready` is 0 are not taken and do not change any result.
- R4: With unsigned 8-bit samples and coefficients, `y` equals K0·x(n)+K1·x(n-1)+K2·x(n-2)+K3·x(n-3) exactly, as an 18-bit unsigned value.
- R5: A write with `coef_we`=1 stores `coef_wdata` as coefficient Ki, where i is the value on `coef_sel` (0..3). An impulse sample of value 1 followed by three zero samples yields K0, K1, K2, K3 on the four successive results.
- R6: `y_valid` is high for exactly one cycle. It rises 4·(18+1) = 76 rising edges after the edge that takes the eighth bit. `y` does not change between results.
- R7: Samples move through the history in order. After reset, missing older samples count as 0 in the sum.
- R8: The largest inputs (all samples and coefficients equal to 255) give 260100 with no overflow. The carry does not leak from one tap's addition into the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| s_valid | input | 1 | Input bit is offered |
| s_ready | output | 1 | Block can take an input bit |
| s_bit | input | 1 | Serial sample bit, least significant bit first |
| coef_we | input | 1 | Coefficient write strobe |
| coef_sel | input | 2 | Index of the coefficient to write |
| coef_wdata | input | 8 | Coefficient value |
| y_valid | output | 1 | One-cycle pulse when a new result is ready |
| y | output | 18 | Filter output, held between results |

## Verification
A faulty carry flop, a wrong tap order or a bad history shift does not hide inside the block. It shows up in the first `y` produced after the faulty state exists, which is at most 76 cycles after the sample that triggered it. An impulse sample followed by zeros exposes tap order within four results. A sweep over all 256 sample values against an arithmetic convolution exposes bit-level faults in the multiplier and the adder. A counter of the cycles to `y_valid` exposes any change in the sequence timing.

// File: rtl/fir_ser_pkg.sv
package fir_ser_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOAD = 2'd1,
    ST_RUN  = 2'd2
  } fir_state_e;
endpackage

// File: rtl/fir_sample_line.sv
module fir_sample_line #(
  parameter int DATA_W = 8,
  parameter int TAPS   = 4,
  parameter int SEL_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_en,
  input  logic              bit_in,
  output logic              sample_done,
  input  logic [SEL_W-1:0]  rd_sel,
  output logic [DATA_W-1:0] rd_data
);
  localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

  logic [DATA_W-1:0] asm_q;
  logic [DATA_W-1:0] assembled;
  logic [CNT_W-1:0]  cnt_q;
  logic [DATA_W-1:0] hist_q [TAPS];

  // new bit enters at the top; after DATA_W shifts the first bit sits at bit 0
  assign assembled   = {bit_in, asm_q[DATA_W-1:1]};
  assign sample_done = bit_en && (cnt_q == LAST_BIT);
  assign rd_data     = hist_q[rd_sel];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      asm_q <= '0;
      cnt_q <= '0;
    end else if (bit_en) begin
      asm_q <= assembled;
      cnt_q <= sample_done ? '0 : cnt_q + 1'b1;
    end
  end

  for (genvar g = 0; g < TAPS; g++) begin : g_hist
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        hist_q[g] <= '0;
      end else if (sample_done) begin
        if (g == 0) hist_q[g] <= assembled;
        else        hist_q[g] <= hist_q[g-1];
      end
    end
  end
endmodule

// File: rtl/fir_sp_mult.sv
module fir_sp_mult #(
  parameter int DATA_W = 8,
  parameter int COEF_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              step,
  input  logic [DATA_W-1:0] x_par,
  input  logic [COEF_W-1:0] coef,
  output logic              prod_bit
);
  logic [DATA_W-1:0] xs_q;
  logic [COEF_W-1:0] coef_q;
  logic [COEF_W-1:0] part_q;
  logic [COEF_W:0]   sum;

  // partial product plus coefficient gated by the current sample bit
  assign sum      = {1'b0, part_q} + (xs_q[0] ? {1'b0, coef_q} : '0);
  assign prod_bit = sum[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      xs_q   <= '0;
      coef_q <= '0;
      part_q <= '0;
    end else if (load) begin
      xs_q   <= x_par;
      coef_q <= coef;
      part_q <= '0;
    end else if (step) begin
      xs_q   <= xs_q >> 1;
      part_q <= sum[COEF_W:1];
    end
  end
endmodule

// File: rtl/fir_serial_acc.sv
module fir_serial_acc #(
  parameter int ACC_W = 18
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_acc,
  input  logic             clear_carry,
  input  logic             step,
  input  logic             add_bit,
  output logic [ACC_W-1:0] acc_next
);
  logic [ACC_W-1:0] acc_q;
  logic             carry_q;
  logic             s_bit;
  logic             c_bit;

  assign s_bit    = acc_q[0] ^ add_bit ^ carry_q;
  assign c_bit    = (acc_q[0] & add_bit) | (acc_q[0] & carry_q) | (add_bit & carry_q);
  assign acc_next = {s_bit, acc_q[ACC_W-1:1]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q   <= '0;
      carry_q <= 1'b0;
    end else begin
      if (clear_acc)   acc_q <= '0;
      else if (step)   acc_q <= acc_next;
      if (clear_carry) carry_q <= 1'b0;
      else if (step)   carry_q <= c_bit;
    end
  end
endmodule

// File: rtl/fir_bitserial.sv
module fir_bitserial #(
  parameter int DATA_W = 8,
  parameter int COEF_W = 8,
  parameter int TAPS   = 4
) (
  input  logic                                          clk,
  input  logic                                          rst_n,
  input  logic                                          s_valid,
  output logic                                          s_ready,
  input  logic                                          s_bit,
  input  logic                                          coef_we,
  input  logic [$clog2(TAPS)-1:0]                       coef_sel,
  input  logic [COEF_W-1:0]                             coef_wdata,
  output logic                                          y_valid,
  output logic [DATA_W+COEF_W+$clog2(TAPS)-1:0]         y
);
  import fir_ser_pkg::*;

  localparam int SEL_W = $clog2(TAPS);
  localparam int ACC_W = DATA_W + COEF_W + SEL_W;
  localparam int CYC_W = $clog2(ACC_W);
  localparam logic [CYC_W-1:0] LAST_CYC = CYC_W'(ACC_W - 1);
  localparam logic [SEL_W-1:0] OLDEST   = SEL_W'(TAPS - 1);

  fir_state_e        state_q;
  logic [SEL_W-1:0]  tap_q;
  logic [CYC_W-1:0]  cyc_q;
  logic [COEF_W-1:0] coef_q [TAPS];
  logic              bit_en;
  logic              sample_done;
  logic [DATA_W-1:0] tap_sample;
  logic              prod_bit;
  logic              do_load;
  logic              do_step;
  logic [ACC_W-1:0]  acc_next;

  assign s_ready = (state_q == ST_IDLE);
  assign bit_en  = s_valid && s_ready;
  assign do_load = (state_q == ST_LOAD);
  assign do_step = (state_q == ST_RUN);

  fir_sample_line #(.DATA_W(DATA_W), .TAPS(TAPS), .SEL_W(SEL_W)) u_line (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .bit_in(s_bit),
    .sample_done(sample_done), .rd_sel(tap_q), .rd_data(tap_sample)
  );

  fir_sp_mult #(.DATA_W(DATA_W), .COEF_W(COEF_W)) u_mult (
    .clk(clk), .rst_n(rst_n), .load(do_load), .step(do_step),
    .x_par(tap_sample), .coef(coef_q[tap_q]), .prod_bit(prod_bit)
  );

  fir_serial_acc #(.ACC_W(ACC_W)) u_acc (
    .clk(clk), .rst_n(rst_n), .clear_acc(sample_done), .clear_carry(do_load),
    .step(do_step), .add_bit(prod_bit), .acc_next(acc_next)
  );

  for (genvar g = 0; g < TAPS; g++) begin : g_coef
    always_ff @(posedge clk) begin
      if (!rst_n)                                  coef_q[g] <= '0;
      else if (coef_we && coef_sel == SEL_W'(g))   coef_q[g] <= coef_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      tap_q   <= '0;
      cyc_q   <= '0;
      y_valid <= 1'b0;
      y       <= '0;
    end else begin
      y_valid <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (sample_done) begin
            state_q <= ST_LOAD;
            tap_q   <= OLDEST;
          end
        end
        ST_LOAD: begin
          cyc_q   <= '0;
          state_q <= ST_RUN;
        end
        ST_RUN: begin
          cyc_q <= cyc_q + 1'b1;
          if (cyc_q == LAST_CYC) begin
            if (tap_q == '0) begin
              state_q <= ST_IDLE;
              y       <= acc_next;
              y_valid <= 1'b1;
            end else begin
              tap_q   <= tap_q - 1'b1;
              state_q <= ST_LOAD;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/fir_bitserial_chk.sv
module fir_bitserial_chk #(
  parameter int DATA_W = 8,
  parameter int COEF_W = 8,
  parameter int TAPS   = 4
) (
  input logic                                  clk,
  input logic                                  rst_n,
  input logic                                  s_ready,
  input logic                                  y_valid,
  input logic [DATA_W+COEF_W+$clog2(TAPS)-1:0] y
);
  localparam int ACC_W = DATA_W + COEF_W + $clog2(TAPS);
  localparam logic [ACC_W-1:0] Y_MAX =
    ACC_W'(TAPS * ((2**DATA_W) - 1) * ((2**COEF_W) - 1));

  // R6
  pulse_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    y_valid |=> !y_valid);

  // R6
  hold_y_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !y_valid |-> $stable(y));

  // R3
  busy_before_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(y_valid) |-> $past(!s_ready));

  // R8
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    y_valid |-> (y <= Y_MAX));
endmodule

bind fir_bitserial fir_bitserial_chk #(.DATA_W(DATA_W), .COEF_W(COEF_W), .TAPS(TAPS)) u_chk (
  .clk(clk), .rst_n(rst_n), .s_ready(s_ready), .y_valid(y_valid), .y(y)
);

// File: tb/fir_bitserial_test.sv
module fir_bitserial_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        s_valid = 1'b0;
  logic        s_ready;
  logic        s_bit = 1'b0;
  logic        coef_we = 1'b0;
  logic [1:0]  coef_sel = '0;
  logic [7:0]  coef_wdata = '0;
  logic        y_valid;
  logic [17:0] y;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int hist [4];
  int kc [4];

  fir_bitserial uut (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready), .s_bit(s_bit),
    .coef_we(coef_we), .coef_sel(coef_sel), .coef_wdata(coef_wdata),
    .y_valid(y_valid), .y(y)
  );

  always #2 clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      errors++;
      $display("FAIL R6 watchdog expired: actual %0d cycles expected fewer", cyc);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr_coef(input int i, input int v);
    @(negedge clk);
    coef_we = 1'b1; coef_sel = 2'(i); coef_wdata = 8'(v);
    @(negedge clk);
    coef_we = 1'b0;
    kc[i] = v;
  endtask

  // sends one sample; optionally floods s_valid while busy; returns y
  task automatic send(input int v, input bit flood, output int result);
    int edges;
    bit busy_ok;
    for (int b = 0; b < 8; b++) begin
      @(negedge clk);
      s_valid = 1'b1; s_bit = v[b];
      @(posedge clk);
    end
    for (int t = 3; t > 0; t--) hist[t] = hist[t-1];
    hist[0] = v;
    edges = 0;
    busy_ok = 1'b1;
    @(negedge clk);
    s_valid = flood; s_bit = 1'b1;
    while (1) begin
      @(posedge clk);
      edges++;
      @(negedge clk);
      if (y_valid) break;
      if (s_ready) busy_ok = 1'b0;
      s_bit = ~s_bit;
      if (edges > 200) break;
    end
    s_valid = 1'b0;
    result = int'(y);
    chk("R6 latency", edges, 76);
    chk("R3 ready low while busy", int'(busy_ok), 1);
    @(posedge clk);
    @(negedge clk);
    chk("R6 single-cycle pulse", int'(y_valid), 0);
    chk("R6 y held", int'(y), result);
  endtask

  function automatic int model();
    int s = 0;
    for (int t = 0; t < 4; t++) s += kc[t] * hist[t];
    return s;
  endfunction

  initial begin
    int r;
    for (int t = 0; t < 4; t++) begin hist[t] = 0; kc[t] = 0; end
    repeat (3) @(negedge clk);
    chk("R1 s_ready", int'(s_ready), 1);
    chk("R1 y_valid", int'(y_valid), 0);
    chk("R1 y", int'(y), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 s_ready after release", int'(s_ready), 1);

    // R1: zero coefficients after reset
    send(200, 1'b0, r);
    chk("R1 zero coefs", r, 0);

    // R5 impulse with R7 history ordering
    wr_coef(0, 17); wr_coef(1, 99); wr_coef(2, 3); wr_coef(3, 250);
    send(0, 1'b0, r); send(0, 1'b0, r); send(0, 1'b0, r); send(0, 1'b0, r);
    send(1, 1'b0, r); chk("R5 impulse K0", r, 17);
    send(0, 1'b0, r); chk("R5 impulse K1", r, 99);
    send(0, 1'b0, r); chk("R5 impulse K2", r, 3);
    send(0, 1'b0, r); chk("R5 impulse K3", r, 250);
    send(0, 1'b0, r); chk("R7 impulse gone", r, 0);

    // R2 R4: sweep every sample value, with R3 flooding on odd values
    for (int v = 0; v < 256; v++) begin
      send(v, v[0], r);
      chk("R4 sweep", r, model());
    end

    // R4: several coefficient sets with pseudo-random samples
    for (int set = 0; set < 4; set++) begin
      for (int t = 0; t < 4; t++) wr_coef(t, (set * 73 + t * 41 + 5) % 256);
      for (int k = 0; k < 24; k++) begin
        send((k * 157 + set * 29 + 11) % 256, 1'b0, r);
        chk("R4 random", r, model());
      end
    end

    // R8 extreme values
    for (int t = 0; t < 4; t++) wr_coef(t, 255);
    for (int k = 0; k < 4; k++) send(255, 1'b1, r);
    chk("R8 max sum", r, 260100);
    send(254, 1'b0, r);
    chk("R8 carry across taps", r, model());

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule